// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block turns one transfer descriptor into the stream of command entries that an I2C master controller takes from its transmit command FIFO. A descriptor carries a direction (read or write), a request for a repeated start on the first entry, a request for a stop on the last entry, and two byte counts. The first count is always sent as data bytes from buffer 0. The second count is sent as more data from buffer 1 on a write, or as one read request per byte on a read. The sequencer watches the transmit FIFO level and throttles itself. It forwards received bytes from the receive FIFO to a valid/ready output, and it ends each transfer with a one-cycle done pulse that carries a status.

The byte memories sit outside the block. They are addressed through a buffer select and an index, and the data returns combinationally. The bus engine also sits outside and is seen only through the two FIFO levels, the FIFO heads and an abort input. A timeout input lets an external watchdog end a transfer that has hung.

The control path has four states. IDLE waits for `start`. FILL pushes entries. HOLD waits for the FIFO to drain. DRAIN waits for completion. The transitions are as follows:
- start: IDLE to FILL.
- no-room: FILL to HOLD, when the push limit is reached.
- resume: HOLD to FILL, when the level is at or below the resume mark.
- all-queued: FILL to DRAIN, when the last phase has no entries left.
- complete: DRAIN to IDLE.
- fault: any busy state to IDLE, on abort, receive surplus or timeout.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Each command entry is 11 bits: bit 10 = restart, bit 9 = stop, bit 8 = read request, bits 7:0 = data. Buffer 0 entries (index 0 up to count A minus 1) come first. On a write they are followed by buffer 1 entries (index 0 up to count B minus 1). Bit 8 is 0 on every data entry.
- R2: On a read, every entry after the buffer 0 bytes is a read request, with bit 8 = 1 and data 0, and there are exactly count B of them. With count A = 0 the first entry is already a read request.
- R3: Bit 10 is set on the first entry of a transfer if, and only if, restart was requested. It is clear on every other entry.
- R4: Bit 9 is set on entry number A+B (the last) if, and only if, stop was requested. It is clear on every other entry.
- R5: On a read, no entry is pushed while the transmit level plus 2 is 64 or more. With enough entries the level reaches exactly 62.
- R6: On a write, entries are pushed while the transmit level is below 64. A long write fills the FIFO to exactly 64 and never past it.
- R7: After a push is refused for lack of room, the next push happens only when the transmit level is 16 or lower.
- R8: A write ends with done and status OK (0) once every entry is queued and the transmit level is 0. A zero-length write also ends this way. Done lasts one cycle and `busy` is low afterwards.
- R9: On a read, received bytes leave on the output in arrival order. Done with status OK follows once count B bytes have been delivered.
- R10: If, during a read, the receive level exceeds the number of bytes still expected, the transfer ends with done and status ERROR (1).
- R11: An abort while busy ends the transfer on the next cycle with done, status ERROR and a one-cycle `abort_clr` pulse. `abort_clr` never rises without done.
- R12: A timeout while busy, with no abort, ends the transfer on the next cycle with done and status TIMEOUT (2).
- R13: During and after reset the block is idle: `busy`, `cmd_valid`, `out_valid` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the descriptor (taken only in IDLE) |
| desc_read | input | 1 | 1 = read transfer, 0 = write |
| desc_restart | input | 1 | Tag the first entry with restart |
| desc_stop | input | 1 | Tag the last entry with stop |
| desc_len_a | input | CNT_W | Buffer 0 byte count |
| desc_len_b | input | CNT_W | Buffer 1 byte count or read length |
| busy | output | 1 | A transfer is in progress |
| src_buf | output | 1 | Buffer select for the byte memories |
| src_idx | output | CNT_W | Byte index within the selected buffer |
| src_data | input | 8 | Byte returned by the memories |
| cmd_valid | output | 1 | Command entry offered |
| cmd_ready | input | 1 | Transmit FIFO accepts the entry |
| cmd_word | output | 11 | Command entry |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_pop | output | 1 | Remove the receive FIFO head |
| rx_data | input | 8 | Receive FIFO head |
| out_valid | output | 1 | Received byte offered |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Received byte |
| abort | input | 1 | Bus engine reports a transfer abort |
| abort_clr | output | 1 | Clears the abort in the bus engine |
| tmo | input | 1 | External watchdog expired |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 0 OK, 1 ERROR, 2 TIMEOUT; valid with done |

## Verification
A wrong phase bit or a wrong byte counter shows up at `cmd_word` on the very entry it corrupts: the wrong buffer byte, a read bit in the wrong place, or a restart or stop flag on the wrong entry. Comparing every entry against an arithmetic model catches it within one push. A wrong room or resume decision shows as a transmit level past 62 on reads or past 64 on writes, or as a push above the resume mark. Both are visible in the cycle the push happens. A wrong receive counter shows as a missing or late done, or as a spurious ERROR, within a few cycles of the last byte.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        SEQ_OK  = 2'd0,
        SEQ_ERR = 2'd1,
        SEQ_TMO = 2'd2
    } seq_status_t;

    localparam int CMD_W    = 11;
    localparam int BIT_RD   = 8;
    localparam int BIT_STOP = 9;
    localparam int BIT_RS   = 10;

endpackage

// File: rtl/i2c_seq_room.sv
// Push permission and resume decision from the transmit FIFO level.
module i2c_seq_room #(
    parameter int DEPTH  = 64,
    parameter int LVL_W  = 7,
    parameter int SLACK  = 2,
    parameter int RESUME = 16
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic             rd_mode,
    output logic             room_ok,
    output logic             resume_ok
);
    localparam int WR_LIMIT = DEPTH;
    localparam int RD_LIMIT = DEPTH - SLACK;

    logic rd_room;
    logic wr_room;

    assign wr_room = int'(tx_level) < WR_LIMIT;

    generate
        if (SLACK == 0) begin : g_no_slack
            assign rd_room = wr_room;
        end else begin : g_slack
            assign rd_room = int'(tx_level) < RD_LIMIT;
        end
    endgenerate

    assign room_ok   = rd_mode ? rd_room : wr_room;
    assign resume_ok = int'(tx_level) <= RESUME;
endmodule

// File: rtl/i2c_seq_tagger.sv
// Builds one command entry from the phase, the running count and the flags.
module i2c_seq_tagger
    import i2c_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             phase2,
    input  logic             rd_mode,
    input  logic             want_rs,
    input  logic             want_sp,
    input  logic [CNT_W:0]   byte_cnt,
    input  logic [CNT_W:0]   total,
    input  logic [7:0]       src_data,
    output logic [CMD_W-1:0] word
);
    logic is_req;

    assign is_req = phase2 && rd_mode;

    always_comb begin
        word           = '0;
        word[7:0]      = is_req ? 8'h00 : src_data;
        word[BIT_RD]   = is_req;
        word[BIT_STOP] = want_sp && ((byte_cnt + 1'b1) == total);
        word[BIT_RS]   = want_rs && (byte_cnt == '0);
    end
endmodule

// File: rtl/i2c_seq_rxtrack.sv
// Counts bytes still expected on a read, forwards the receive FIFO head
// and flags a surplus in the receive FIFO.
module i2c_seq_rxtrack #(
    parameter int CNT_W = 8,
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             active,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             rx_pop,
    output logic             remain_zero,
    output logic             surplus
);
    logic [CNT_W-1:0] remain_q;

    assign out_valid   = active && (rx_level != '0);
    assign rx_pop      = out_valid && out_ready;
    assign remain_zero = (remain_q == '0);
    assign surplus     = active && (int'(rx_level) > int'(remain_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_cnt;
        end else if (rx_pop && !remain_zero) begin
            remain_q <= remain_q - 1'b1;
        end
    end
endmodule

// File: rtl/i2c_cmd_seq.sv
// Two-phase command sequencer for an I2C master command FIFO.
module i2c_cmd_seq
    import i2c_seq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 64,
    parameter  int CNT_W      = 8,
    parameter  int TX_RESUME  = 16,
    parameter  int RX_SLACK   = 2,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             desc_read,
    input  logic             desc_restart,
    input  logic             desc_stop,
    input  logic [CNT_W-1:0] desc_len_a,
    input  logic [CNT_W-1:0] desc_len_b,
    output logic             busy,
    output logic             src_buf,
    output logic [CNT_W-1:0] src_idx,
    input  logic [7:0]       src_data,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [CMD_W-1:0] cmd_word,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output logic             rx_pop,
    input  logic [7:0]       rx_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    input  logic             abort,
    output logic             abort_clr,
    input  logic             tmo,
    output logic             done,
    output logic [1:0]       status
);
    seq_state_t  st_q, st_d;
    seq_status_t status_q, status_d;
    logic rd_q, rd_d, rs_q, rs_d, sp_q, sp_d, ph2_q, ph2_d;
    logic done_q, done_d, clr_q, clr_d;
    logic [CNT_W-1:0] la_q, la_d, lb_q, lb_d, idx_q, idx_d;
    logic [CNT_W:0]   bcnt_q, bcnt_d;

    logic [CNT_W-1:0] cur_len;
    logic [CNT_W:0]   total_w;
    logic             left, room_ok, resume_ok, remain_zero, surplus;
    logic             fault, push, rx_active, rx_load;

    assign cur_len   = ph2_q ? lb_q : la_q;
    assign left      = (idx_q != cur_len);
    assign total_w   = {1'b0, la_q} + {1'b0, lb_q};
    assign rx_active = (st_q != ST_IDLE) && rd_q;
    assign rx_load   = (st_q == ST_IDLE) && start;
    assign fault     = (st_q != ST_IDLE) && (abort || surplus || tmo);
    assign push      = cmd_valid && cmd_ready;

    i2c_seq_room #(
        .DEPTH (FIFO_DEPTH),
        .LVL_W (LVL_W),
        .SLACK (RX_SLACK),
        .RESUME(TX_RESUME)
    ) u_room (
        .tx_level (tx_level),
        .rd_mode  (rd_q),
        .room_ok  (room_ok),
        .resume_ok(resume_ok)
    );

    i2c_seq_tagger #(
        .CNT_W(CNT_W)
    ) u_tag (
        .phase2  (ph2_q),
        .rd_mode (rd_q),
        .want_rs (rs_q),
        .want_sp (sp_q),
        .byte_cnt(bcnt_q),
        .total   (total_w),
        .src_data(src_data),
        .word    (cmd_word)
    );

    i2c_seq_rxtrack #(
        .CNT_W(CNT_W),
        .LVL_W(LVL_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (rx_load),
        .load_cnt   (desc_len_b),
        .active     (rx_active),
        .rx_level   (rx_level),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .rx_pop     (rx_pop),
        .remain_zero(remain_zero),
        .surplus    (surplus)
    );

    // Next-state and datapath decisions
    always_comb begin
        st_d     = st_q;
        status_d = status_q;
        rd_d     = rd_q;
        rs_d     = rs_q;
        sp_d     = sp_q;
        ph2_d    = ph2_q;
        la_d     = la_q;
        lb_d     = lb_q;
        idx_d    = idx_q;
        bcnt_d   = bcnt_q;
        done_d   = 1'b0;
        clr_d    = 1'b0;

        if (fault) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            if (abort) begin
                status_d = SEQ_ERR;
                clr_d    = 1'b1;
            end else if (surplus) begin
                status_d = SEQ_ERR;
            end else begin
                status_d = SEQ_TMO;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_d   = ST_FILL;
                        rd_d   = desc_read;
                        rs_d   = desc_restart;
                        sp_d   = desc_stop;
                        la_d   = desc_len_a;
                        lb_d   = desc_len_b;
                        ph2_d  = (desc_len_a == '0);
                        idx_d  = '0;
                        bcnt_d = '0;
                    end
                end
                ST_FILL: begin
                    if (!left) begin
                        st_d = ST_DRAIN;
                    end else if (!room_ok) begin
                        st_d = ST_HOLD;
                    end else if (push) begin
                        bcnt_d = bcnt_q + 1'b1;
                        if (!ph2_q && ((idx_q + 1'b1) == la_q) && (lb_q != '0)) begin
                            ph2_d = 1'b1;
                            idx_d = '0;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (resume_ok) begin
                        st_d = ST_FILL;
                    end
                end
                ST_DRAIN: begin
                    if (rd_q ? remain_zero : (tx_level == '0)) begin
                        st_d     = ST_IDLE;
                        done_d   = 1'b1;
                        status_d = SEQ_OK;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            status_q <= SEQ_OK;
            rd_q     <= 1'b0;
            rs_q     <= 1'b0;
            sp_q     <= 1'b0;
            ph2_q    <= 1'b0;
            la_q     <= '0;
            lb_q     <= '0;
            idx_q    <= '0;
            bcnt_q   <= '0;
            done_q   <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            st_q     <= st_d;
            status_q <= status_d;
            rd_q     <= rd_d;
            rs_q     <= rs_d;
            sp_q     <= sp_d;
            ph2_q    <= ph2_d;
            la_q     <= la_d;
            lb_q     <= lb_d;
            idx_q    <= idx_d;
            bcnt_q   <= bcnt_d;
            done_q   <= done_d;
            clr_q    <= clr_d;
        end
    end

    // Outputs
    always_comb begin
        busy      = (st_q != ST_IDLE);
        cmd_valid = (st_q == ST_FILL) && left && room_ok && !fault;
        src_buf   = ph2_q;
        src_idx   = idx_q;
        out_data  = rx_data;
        done      = done_q;
        status    = status_q;
        abort_clr = clr_q;
    end
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
// Assertions for the command sequencer, bound to the top module.
module i2c_cmd_seq_chk #(
    parameter  int FIFO_DEPTH = 64,
    parameter  int CNT_W      = 8,
    parameter  int RX_SLACK   = 2,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cmd_valid,
    input logic [10:0]      cmd_word,
    input logic [LVL_W-1:0] tx_level,
    input logic             abort,
    input logic             tmo,
    input logic             done,
    input logic [1:0]       status,
    input logic             abort_clr,
    input logic             out_valid,
    input logic             rd_mode,
    input logic [CNT_W:0]   bcnt,
    input logic [CNT_W:0]   total
);
    assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (int'(tx_level) < FIFO_DEPTH));

    assert_read_slack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && rd_mode) |-> (int'(tx_level) + RX_SLACK < FIFO_DEPTH));

    assert_restart_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[10]) |-> (bcnt == '0));

    assert_stop_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[9]) |-> ((bcnt + 1'b1) == total));

    assert_abort_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (done && abort_clr && status == 2'd1));

    assert_clr_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_clr |-> done);

    assert_tmo_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tmo && !abort) |=> (done && status != 2'd0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_out_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .CNT_W     (CNT_W),
    .RX_SLACK  (RX_SLACK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .cmd_valid(cmd_valid),
    .cmd_word (cmd_word),
    .tx_level (tx_level),
    .abort    (abort),
    .tmo      (tmo),
    .done     (done),
    .status   (status),
    .abort_clr(abort_clr),
    .out_valid(out_valid),
    .rd_mode  (rd_q),
    .bcnt     (bcnt_q),
    .total    (total_w)
);

// File: tb/sim_i2c_cmd_seq.sv
module sim_i2c_cmd_seq;
    localparam int DEPTH = 64;
    localparam int CW    = 8;
    localparam int LW    = 7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, start, d_rd, d_rs, d_sp;
    logic [CW-1:0] d_la, d_lb;
    logic          busy, src_buf;
    logic [CW-1:0] src_idx;
    logic [7:0]    src_data;
    logic          cmd_valid, cmd_ready;
    logic [10:0]   cmd_word;
    logic [LW-1:0] tx_level, rx_level;
    logic          rx_pop;
    logic [7:0]    rx_data;
    logic          out_valid, out_ready;
    logic [7:0]    out_data;
    logic          abort, abort_clr, tmo, done;
    logic [1:0]    status;

    int n_chk  = 0;
    int n_fail = 0;

    function automatic logic [7:0] mem_byte(input logic b, input logic [7:0] i);
        return b ? (8'h80 ^ i) : (8'h10 + i * 8'd3);
    endfunction

    assign src_data  = mem_byte(src_buf, src_idx);
    assign cmd_ready = int'(tx_level) < DEPTH;
    assign out_ready = 1'b1;

    i2c_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .desc_read(d_rd), .desc_restart(d_rs), .desc_stop(d_sp),
        .desc_len_a(d_la), .desc_len_b(d_lb), .busy(busy),
        .src_buf(src_buf), .src_idx(src_idx), .src_data(src_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .tx_level(tx_level), .rx_level(rx_level), .rx_pop(rx_pop),
        .rx_data(rx_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .abort(abort), .abort_clr(abort_clr),
        .tmo(tmo), .done(done), .status(status)
    );

    // Bus engine and FIFO model
    logic [10:0] txq[$];
    logic [7:0]  rxq[$];
    logic [10:0] got_w[$];
    logic [7:0]  got_b[$];
    logic        flush = 1'b0;
    logic        inj   = 1'b0;
    int          tick, rx_k, max_lvl, viol;
    bit          held;

    always @(posedge clk) begin
        logic [10:0] w;
        if (!rst_n || flush) begin
            txq.delete(); rxq.delete(); got_w.delete(); got_b.delete();
            tick = 0; rx_k = 0; max_lvl = 0; viol = 0; held = 0;
            tx_level <= '0; rx_level <= '0; rx_data <= '0;
        end else begin
            if (rx_pop && rxq.size() > 0) begin
                got_b.push_back(rxq[0]);
                void'(rxq.pop_front());
            end
            if (cmd_valid && cmd_ready) begin
                if (held && int'(tx_level) > 16) viol++;
                held = 0;
                got_w.push_back(cmd_word);
                txq.push_back(cmd_word);
            end else if (busy && !(d_rd ? (int'(tx_level) + 2 < DEPTH)
                                        : (int'(tx_level) < DEPTH))) begin
                held = 1;
            end
            tick++;
            if (tick % 3 == 0 && txq.size() > 0) begin
                w = txq.pop_front();
                if (w[8]) begin
                    rxq.push_back(8'h3C + 8'(rx_k * 7));
                    rx_k++;
                end
            end
            if (inj) repeat (5) rxq.push_back(8'hEE);
            if (txq.size() > max_lvl) max_lvl = txq.size();
            tx_level <= LW'(txq.size());
            rx_level <= LW'(rxq.size());
            rx_data  <= (rxq.size() > 0) ? rxq[0] : 8'h00;
        end
    end

    task automatic chk(input bit c, input string tag, input int act, input int exp);
        n_chk++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic kick(input bit rd, input bit rs, input bit sp, input int la, input int lb);
        @(negedge clk);
        d_rd = rd; d_rs = rs; d_sp = sp; d_la = CW'(la); d_lb = CW'(lb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int lim, output bit seen, output int st);
        seen = 0; st = -1;
        for (int c = 0; c < lim; c++) begin
            if (done) begin seen = 1; st = int'(status); break; end
            @(negedge clk);
        end
    endtask

    task automatic run_xfer(input bit rd, input bit rs, input bit sp, input int la, input int lb);
        int total;
        bit seen;
        int st;
        logic [10:0] e;
        total = la + lb;
        kick(rd, rs, sp, la, lb);
        wait_done(4000, seen, st);
        chk(seen, rd ? "R9 done" : "R8 done", int'(seen), 1);
        chk(st == 0, rd ? "R9 status" : "R8 status", st, 0);
        @(negedge clk);
        chk(!busy && !done, "R8 idle after done", int'(busy), 0);
        chk(got_w.size() == total, "R1 entry count", got_w.size(), total);
        for (int n = 0; n < got_w.size() && n < total; n++) begin
            e = '0;
            if (n < la)      e[7:0] = mem_byte(1'b0, 8'(n));
            else if (!rd)    e[7:0] = mem_byte(1'b1, 8'(n - la));
            else             e[8]   = 1'b1;
            e[10] = rs && (n == 0);
            e[9]  = sp && (n == total - 1);
            chk(got_w[n][8:0] == e[8:0], (rd && n >= la) ? "R2 read request" : "R1 data entry",
                int'(got_w[n][8:0]), int'(e[8:0]));
            chk(got_w[n][10] == e[10], "R3 restart flag", int'(got_w[n][10]), int'(e[10]));
            chk(got_w[n][9] == e[9], "R4 stop flag", int'(got_w[n][9]), int'(e[9]));
        end
        if (rd) begin
            chk(got_b.size() == lb, "R9 byte count", got_b.size(), lb);
            for (int k = 0; k < got_b.size() && k < lb; k++)
                chk(got_b[k] == 8'h3C + 8'(k * 7), "R9 byte order",
                    int'(got_b[k]), int'(8'h3C + 8'(k * 7)));
            chk(max_lvl <= DEPTH - 2, "R5 read slack", max_lvl, DEPTH - 2);
            if (total >= 100) chk(max_lvl == DEPTH - 2, "R5 slack boundary", max_lvl, DEPTH - 2);
        end else begin
            chk(max_lvl <= DEPTH, "R6 no overfill", max_lvl, DEPTH);
            if (total >= 100) chk(max_lvl == DEPTH, "R6 fills to depth", max_lvl, DEPTH);
        end
        chk(viol == 0, "R7 resume mark", viol, 0);
        do_flush();
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL R8 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        int st;
        rst_n = 1'b0; start = 1'b0; d_rd = 1'b0; d_rs = 1'b0; d_sp = 1'b0;
        d_la = '0; d_lb = '0; abort = 1'b0; tmo = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !cmd_valid && !out_valid && !done, "R13 reset state",
            int'({busy, cmd_valid, out_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cmd_valid && !done, "R13 after reset", int'({busy, cmd_valid, done}), 0);

        // Sweep of flags and lengths, writes then reads
        for (int f = 0; f < 4; f++) begin
            run_xfer(1'b0, f[0], f[1], 3, 0);
            run_xfer(1'b0, f[0], f[1], 0, 4);
            run_xfer(1'b0, f[0], f[1], 2, 5);
            run_xfer(1'b0, f[0], f[1], 1, 1);
            run_xfer(1'b0, f[0], f[1], 0, 0);
            run_xfer(1'b0, f[0], f[1], 5, 100);
            run_xfer(1'b1, f[0], f[1], 0, 1);
            run_xfer(1'b1, f[0], f[1], 2, 5);
            run_xfer(1'b1, f[0], f[1], 3, 2);
            run_xfer(1'b1, f[0], f[1], 0, 70);
            run_xfer(1'b1, f[0], f[1], 5, 100);
        end

        // Abort mid-transfer (R11)
        kick(1'b0, 1'b1, 1'b1, 5, 100);
        repeat (20) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(done && status == 2'd1, "R11 abort status", int'({done, status}), 5);
        chk(abort_clr, "R11 abort clear pulse", int'(abort_clr), 1);
        @(negedge clk);
        chk(!busy && !cmd_valid && !abort_clr, "R11 idle after abort",
            int'({busy, cmd_valid, abort_clr}), 0);
        do_flush();

        // Timeout mid-transfer (R12)
        kick(1'b1, 1'b0, 1'b1, 0, 70);
        repeat (15) @(negedge clk);
        tmo = 1'b1;
        @(negedge clk);
        tmo = 1'b0;
        chk(done && status == 2'd2, "R12 timeout status", int'({done, status}), 6);
        chk(!abort_clr, "R12 no abort clear", int'(abort_clr), 0);
        @(negedge clk);
        chk(!busy, "R12 idle after timeout", int'(busy), 0);
        do_flush();

        // Receive surplus (R10)
        kick(1'b1, 1'b1, 1'b1, 0, 3);
        inj = 1'b1;
        @(negedge clk);
        inj = 1'b0;
        wait_done(20, seen, st);
        chk(seen && st == 1, "R10 surplus error", st, 1);
        do_flush();

        // A normal transfer still works after the faults
        run_xfer(1'b1, 1'b1, 1'b1, 2, 5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule